// File: doc/BRIEF.md
# Bidirectional Parallel/Serial Bus Register

This block is an eight-stage storage register placed between two parallel buses, called A and B. It can take a word from either bus and present it on the other. It can also shift serial data in and present the result in parallel, or take a word from a bus and shift it out serially from its last stage. When the word must stay unchanged, it holds it by recirculation. Each bus port is modelled as three vectors: an input, an output value and a per-bit output enable. A wrapper outside the block builds the tri-state pads.

Four static controls set the behaviour:

- `dir_a2b` picks which port is the source and which port is driven.
- `par_sel` picks parallel transfer or serial shifting.
- `async_sel` picks clocked or unclocked parallel transfer.
- `a_en` lets port A be disconnected completely, so several registers can share one A bus.

An unclocked transfer is a combinational pass-through from the source port to the driven port. The register also samples that source on every clock, so the word is kept once the controls change.

Top module: `bus_shift_reg`

## Requirements
- R1: When `dir_a2b`=1, `b_oe` is all ones and `a_oe` is all zeros. When `dir_a2b`=0 and `a_en`=1, `a_oe` is all ones and `b_oe` is all zeros. A port whose enable is all zeros shows 0 on its output vector.
- R2: While `a_en`=0, `a_oe` stays all zeros and the value on `a_in` never reaches the register or any output.
- R3: With `par_sel`=0, each rising clock edge moves bit i to bit i+1 and places `ser_in` in bit 0, whatever the value of `async_sel`. `ser_out` always equals bit 7 of the stored word.
- R4: With `par_sel`=1, `async_sel`=0, `dir_a2b`=1 and `a_en`=1, `a_in` is stored on the rising edge, and `b_out` shows the stored word.
- R5: With `par_sel`=1 and `async_sel`=1, the driven port shows the source word in the same cycle with no clock edge. The register also stores that word on each rising edge, so the word remains after the mode changes.
- R6: With `par_sel`=1, `dir_a2b`=1 and `a_en`=0, the stored word is held unchanged by recirculation, and `b_out` shows it.
- R7: With `par_sel`=1 and `dir_a2b`=0, the word on `b_in` is stored on each rising edge. Port A is driven only if `a_en`=1.
- R8: In serial mode, the driven port shows the stored word. With `a_en`=0 and `dir_a2b`=0, neither port is driven.
- R9: `rst_n`=0 clears all stages to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| a_en | input | 1 | Connects port A when 1 |
| dir_a2b | input | 1 | 1: A is the source and B is driven; 0: B is the source and A is driven |
| par_sel | input | 1 | 1: parallel transfer; 0: serial shift |
| async_sel | input | 1 | 1: unclocked parallel transfer (ignored in serial mode) |
| ser_in | input | 1 | Serial data into stage 0 |
| a_in | input | 8 | Value read from bus A |
| a_out | output | 8 | Value to drive on bus A |
| a_oe | output | 8 | Per-bit output enable for bus A |
| b_in | input | 8 | Value read from bus B |
| b_out | output | 8 | Value to drive on bus B |
| b_oe | output | 8 | Per-bit output enable for bus B |
| ser_out | output | 1 | Stage 7 |

## Verification
The assertions assume that the four controls are stable around each rising clock edge, and that the source port does not change across an edge while an unclocked transfer is selected. The bench changes every input only at the falling edge, so both assumptions hold. The bench sweeps all sixteen control combinations. For each combination it applies eight data words and serial bits computed by formula. A reset partway through the run checks the asynchronous clear.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Port-drive and source decode derived from the four static controls.
  typedef struct packed {
    logic drive_a;   // port A output enabled
    logic drive_b;   // port B output enabled
    logic src_a;     // parallel source is port A
    logic src_b;     // parallel source is port B
    logic recirc;    // parallel source is the register itself
    logic load_par;  // register takes the parallel source on the edge
    logic bypass;    // driven port follows the source combinationally
  } bsr_ctl_t;

  function automatic bsr_ctl_t decode_ctl(input logic a_en, input logic dir_a2b,
                                          input logic par_sel, input logic async_sel);
    bsr_ctl_t c;
    c.drive_a  = a_en & ~dir_a2b;
    c.drive_b  = dir_a2b;
    c.src_a    = dir_a2b & a_en;
    c.src_b    = ~dir_a2b;
    c.recirc   = dir_a2b & ~a_en;
    c.load_par = par_sel;
    c.bypass   = par_sel & async_sel;
    return c;
  endfunction

endpackage

// File: rtl/bsr_src_sel.sv
module bsr_src_sel
  import bsr_pkg::*;
#(
  parameter int W = 8
) (
  input  bsr_ctl_t       ctl,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  input  logic [W-1:0]   stage_q,
  output logic [W-1:0]   par_src
);

  function automatic logic [W-1:0] pick_src(input bsr_ctl_t c, input logic [W-1:0] a,
                                            input logic [W-1:0] b, input logic [W-1:0] q);
    logic [W-1:0] r;
    r = q;
    if (c.src_a) r = a;
    else if (c.src_b) r = b;
    return r;
  endfunction

  assign par_src = pick_src(ctl, a_in, b_in, stage_q);

endmodule

// File: rtl/bsr_stage_array.sv
module bsr_stage_array #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_par,
  input  logic [W-1:0] par_src,
  input  logic         ser_in,
  output logic [W-1:0] stage_q
);

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic ser_d;
    if (i == 0) begin : g_head
      assign ser_d = ser_in;
    end else begin : g_body
      assign ser_d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= load_par ? par_src[i] : ser_d;
    end
  end

endmodule

// File: rtl/bsr_out_path.sv
module bsr_out_path
  import bsr_pkg::*;
#(
  parameter int W = 8
) (
  input  bsr_ctl_t     ctl,
  input  logic [W-1:0] par_src,
  input  logic [W-1:0] stage_q,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic [W-1:0] shown;

  assign shown = ctl.bypass ? par_src : stage_q;
  assign a_oe  = {W{ctl.drive_a}};
  assign b_oe  = {W{ctl.drive_b}};
  assign a_out = ctl.drive_a ? shown : '0;
  assign b_out = ctl.drive_b ? shown : '0;

endmodule

// File: rtl/bus_shift_reg.sv
module bus_shift_reg
  import bsr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_en,
  input  logic         dir_a2b,
  input  logic         par_sel,
  input  logic         async_sel,
  input  logic         ser_in,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic         ser_out
);

  bsr_ctl_t     ctl;
  logic [W-1:0] par_src;
  logic [W-1:0] stage_q;

  // Named events for the checker.
  logic ev_shift, ev_load_a, ev_load_b, ev_recirc;

  assign ctl       = decode_ctl(a_en, dir_a2b, par_sel, async_sel);
  assign ev_shift  = ~ctl.load_par;
  assign ev_load_a = ctl.load_par & ctl.src_a;
  assign ev_load_b = ctl.load_par & ctl.src_b;
  assign ev_recirc = ctl.load_par & ctl.recirc;

  bsr_src_sel #(.W(W)) u_src (
    .ctl(ctl), .a_in(a_in), .b_in(b_in), .stage_q(stage_q), .par_src(par_src)
  );

  bsr_stage_array #(.W(W)) u_stages (
    .clk(clk), .rst_n(rst_n), .load_par(ctl.load_par), .par_src(par_src),
    .ser_in(ser_in), .stage_q(stage_q)
  );

  bsr_out_path #(.W(W)) u_out (
    .ctl(ctl), .par_src(par_src), .stage_q(stage_q),
    .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  assign ser_out = stage_q[W-1];

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         a_en,
  input logic         dir_a2b,
  input logic         async_sel,
  input logic         ser_in,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] stage_q,
  input logic         ev_shift,
  input logic         ev_load_a,
  input logic         ev_load_b,
  input logic         ev_recirc
);

  p_dir_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dir_a2b |-> (b_oe == {W{1'b1}} && a_oe == '0));

  p_dir_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_a2b && a_en) |-> (a_oe == {W{1'b1}} && b_oe == '0));

  p_quiet_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |-> a_oe == '0);

  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift |=> stage_q == {$past(stage_q[W-2:0]), $past(ser_in)});

  p_load_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_a |=> stage_q == $past(a_in));

  p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load_a && async_sel) |-> b_out == a_in);

  p_recirc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_recirc |=> $stable(stage_q));

  p_load_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_b |=> stage_q == $past(b_in));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r9: assert (stage_q == '0);
    end
  end

endmodule

bind bus_shift_reg bsr_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_en(a_en), .dir_a2b(dir_a2b), .async_sel(async_sel),
  .ser_in(ser_in), .a_in(a_in), .b_in(b_in), .a_oe(a_oe), .b_oe(b_oe), .b_out(b_out),
  .stage_q(stage_q), .ev_shift(ev_shift), .ev_load_a(ev_load_a),
  .ev_load_b(ev_load_b), .ev_recirc(ev_recirc)
);

// File: tb/sim_bus_shift_reg.sv
module sim_bus_shift_reg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_en = 1'b0, dir_a2b = 1'b1, par_sel = 1'b0, async_sel = 1'b0, ser_in = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic [7:0] a_out, a_oe, b_out, b_oe;
  logic       ser_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int qm = 0;  // model of stored word

  bus_shift_reg #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .dir_a2b(dir_a2b), .par_sel(par_sel),
    .async_sel(async_sel), .ser_in(ser_in), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One step: drive at the falling edge, check combinational view, model the rising edge.
  task automatic step(input int ctl, input int av, input int bv, input int sv);
    int en, dir, par, asy, src, shown, ea, eb, nxt;
    string tag;
    @(negedge clk);
    en = (ctl >> 3) & 1; dir = (ctl >> 2) & 1; par = (ctl >> 1) & 1; asy = ctl & 1;
    a_en = en[0]; dir_a2b = dir[0]; par_sel = par[0]; async_sel = asy[0];
    a_in = av[7:0]; b_in = bv[7:0]; ser_in = sv[0];
    #1;
    if (dir == 1) src = (en == 1) ? av : qm;
    else          src = bv;
    shown = (par == 1 && asy == 1) ? src : qm;
    ea = (en == 1 && dir == 0) ? shown : 0;
    eb = (dir == 1) ? shown : 0;
    if (par == 0) tag = "R8";
    else if (asy == 1) tag = "R5";
    else if (dir == 0) tag = "R7";
    else if (en == 0) tag = "R6";
    else tag = "R4";
    chk((en == 0) ? "R2 a_oe" : "R1 a_oe", int'(a_oe), (en == 1 && dir == 0) ? 255 : 0);
    chk("R1 b_oe", int'(b_oe), (dir == 1) ? 255 : 0);
    chk({tag, " a_out"}, int'(a_out), ea);
    chk({tag, " b_out"}, int'(b_out), eb);
    chk("R3 ser_out", int'(ser_out), (qm / 128) % 2);
    if (par == 1) nxt = src;
    else          nxt = (qm * 2 + sv) % 256;  // R3 shift toward MSB
    @(posedge clk);
    qm = nxt;
  endtask

  initial begin
    #3;
    chk("R9 reset b_out", int'(b_out), 0);
    chk("R9 reset ser_out", int'(ser_out), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 8; k++) begin
        step(c, (c * 29 + k * 71 + 3) % 256, (c * 53 + k * 17 + 200) % 256, (c + k) % 2);
      end
    end
    // Serial fill of ones with async_sel high (R3: async ignored).
    for (int k = 0; k < 8; k++) step(4'b0101, 0, 0, 1);
    step(4'b0100, 0, 0, 0);
    // R9: asynchronous clear between edges.
    step(4'b1110, 8'hA5, 0, 0);
    @(negedge clk);
    a_en = 1'b0; dir_a2b = 1'b1; par_sel = 1'b1; async_sel = 1'b0;
    #1;
    chk("R6 before clear", int'(b_out), 8'hA5);
    #1 rst_n = 1'b0;
    #1;
    chk("R9 async clear b_out", int'(b_out), 0);
    chk("R9 async clear ser_out", int'(ser_out), 0);
    qm = 0;
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b0100, 0, 0, 1);
    step(4'b0100, 0, 0, 0);
    step(4'b0110, 0, 0, 0);  // R6 recirc shows 0000_0010
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule